// File: doc/BRIEF.md
# Descriptor Completion Decision Unit

When a descriptor finishes, a descriptor-driven DMA channel has to make three decisions. It can stall and retry the same descriptor. It can signal the processor. It can jump to the address held in the descriptor's dependent word or step on to the next descriptor. This unit makes all three decisions from one completion strobe and keeps the channel's command pointer and branch-taken flag.

Each decision has a 2-bit mode field in the descriptor. The decision also tests a condition: the channel's 4-bit device status is masked and compared against a per-decision compare value, under a per-decision mask. The register file outside the unit holds the select registers, with the mask in bits 19:16 and the compare value in bits 3:0. It delivers those two fields as separate ports.

The wait decision takes priority. A channel that waits produces no interrupt and leaves its pointer untouched. The surrounding sequencer then retries the descriptor. Interrupt pulses feed a sticky pending latch, which software clears.

Top module: `cbwi_unit`

## Requirements
- R1: After reset, cmdPtr is 0, btFlag is 0, irqPending is 0 and decValid is 0.
- R2: A decision's condition is true exactly when (devStatus AND mask) equals (compare value AND mask). Each decision uses its own mask and compare value, all 4 bits wide, and a zero mask always gives true.
- R3: Each 2-bit mode field encodes 0 = never, 1 = act when the condition is true, 2 = act when the condition is false, 3 = always. This holds identically for the wait, interrupt and branch fields.
- R4: The inputs are sampled on the clock edge that sees evalStrobe high. decValid is high for exactly the following cycle. waitFlag, irqPulse and branchTaken carry that decision during that cycle and are 0 whenever decValid is 0.
- R5: When the wait decision fires, irqPulse and branchTaken are 0, and cmdPtr and btFlag keep their values across the commit edge.
- R6: When the channel does not wait and the branch fires, cmdPtr becomes the sampled depWord and btFlag becomes 1 on the edge that ends the decValid cycle.
- R7: When the channel does not wait and the branch does not fire, cmdPtr advances by 16 modulo 2^ADDR_W and btFlag becomes 0 on that same edge.
- R8: irqPending is set on the edge that ends an irqPulse cycle. It stays set until an edge that sees irqClear high with no irqPulse. When both occur together, the set wins.
- R9: An edge that sees ptrLoad high loads cmdPtr with ptrLoadValue with its low 4 bits cleared, unless a branch or advance commits on that same edge, in which case the commit wins and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evalStrobe | input | 1 | Descriptor completion, samples all decision inputs |
| waitMode | input | 2 | Wait mode field of the descriptor |
| intrMode | input | 2 | Interrupt mode field of the descriptor |
| branchMode | input | 2 | Branch mode field of the descriptor |
| devStatus | input | STAT_W | Device status bits of the channel |
| waitMask | input | STAT_W | Wait select mask |
| waitValue | input | STAT_W | Wait select compare value |
| intrMask | input | STAT_W | Interrupt select mask |
| intrValue | input | STAT_W | Interrupt select compare value |
| branchMask | input | STAT_W | Branch select mask |
| branchValue | input | STAT_W | Branch select compare value |
| depWord | input | ADDR_W | Branch target from the descriptor's dependent word |
| ptrLoad | input | 1 | Software write of the command pointer |
| ptrLoadValue | input | ADDR_W | Value written to the command pointer |
| irqClear | input | 1 | Clears the pending interrupt latch |
| decValid | output | 1 | Decision outputs valid this cycle |
| waitFlag | output | 1 | The channel must wait and retry |
| irqPulse | output | 1 | One-cycle interrupt request |
| branchTaken | output | 1 | The branch is taken |
| cmdPtr | output | ADDR_W | Command pointer |
| btFlag | output | 1 | Branch-taken status bit |
| irqPending | output | 1 | Sticky interrupt latch |

## Verification
The bench builds the unit with ADDR_W = 16 and STAT_W = 4, keeping the 16-byte descriptor step. The narrow pointer makes the wrap from 0xFFF0 to 0x0000 on fall-through reachable with a single descriptor. It also keeps branch targets and load values easy to read. The four status bits let directed patterns cover full, partial and zero masks on every decision, in each of the four modes.

// File: rtl/cbwi_pkg.sv
package cbwi_pkg;

  typedef enum logic [1:0] {
    MODE_NEVER    = 2'd0,
    MODE_IF_TRUE  = 2'd1,
    MODE_IF_FALSE = 2'd2,
    MODE_ALWAYS   = 2'd3
  } cbwi_mode_e;

  localparam int DEC_COUNT  = 3;
  localparam int DEC_WAIT   = 0;
  localparam int DEC_INTR   = 1;
  localparam int DEC_BRANCH = 2;

  typedef struct packed {
    logic commitBranch;
    logic commitAdvance;
    logic raiseIrq;
  } cbwi_strobe_t;

  function automatic logic modeFires(cbwi_mode_e mode, logic hit);
    logic fires;
    unique case (mode)
      MODE_NEVER:    fires = 1'b0;
      MODE_IF_TRUE:  fires = hit;
      MODE_IF_FALSE: fires = !hit;
      default:       fires = 1'b1;
    endcase
    return fires;
  endfunction

endpackage

// File: rtl/cbwi_cond_eval.sv
module cbwi_cond_eval #(
  parameter int STAT_W = 4
) (
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] mask,
  input  logic [STAT_W-1:0] value,
  output logic              hit
);
  logic [STAT_W-1:0] diff;

  always_comb begin
    diff = (status ^ value) & mask;
    hit  = (diff == '0);
  end
endmodule

// File: rtl/cbwi_datapath.sv
module cbwi_datapath
  import cbwi_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int STAT_W     = 4,
  parameter int STEP_BYTES = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               capture,
  input  logic [STAT_W-1:0]                  devStatus,
  input  logic [DEC_COUNT-1:0][STAT_W-1:0]   maskIn,
  input  logic [DEC_COUNT-1:0][STAT_W-1:0]   valueIn,
  input  logic [ADDR_W-1:0]                  depWord,
  input  logic                               ptrLoad,
  input  logic [ADDR_W-1:0]                  ptrLoadValue,
  input  logic                               irqClear,
  input  cbwi_strobe_t                       strobes,
  output logic [DEC_COUNT-1:0]               condHit,
  output logic [ADDR_W-1:0]                  cmdPtr,
  output logic                               btFlag,
  output logic                               irqPending
);
  localparam int ALIGN_BITS = $clog2(STEP_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = {ADDR_W{1'b1}} << ALIGN_BITS;
  localparam logic [ADDR_W-1:0] STEP_VAL = ADDR_W'(STEP_BYTES);

  logic [STAT_W-1:0]                statusCap;
  logic [DEC_COUNT-1:0][STAT_W-1:0] maskCap;
  logic [DEC_COUNT-1:0][STAT_W-1:0] valueCap;
  logic [ADDR_W-1:0]                depCap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusCap <= '0;
      maskCap   <= '0;
      valueCap  <= '0;
      depCap    <= '0;
    end else if (capture) begin
      statusCap <= devStatus;
      maskCap   <= maskIn;
      valueCap  <= valueIn;
      depCap    <= depWord;
    end
  end

  for (genvar d = 0; d < DEC_COUNT; d++) begin : g_cond
    cbwi_cond_eval #(.STAT_W(STAT_W)) u_eval (
      .status (statusCap),
      .mask   (maskCap[d]),
      .value  (valueCap[d]),
      .hit    (condHit[d])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdPtr <= '0;
      btFlag <= 1'b0;
    end else if (strobes.commitBranch) begin
      cmdPtr <= depCap;
      btFlag <= 1'b1;
    end else if (strobes.commitAdvance) begin
      cmdPtr <= cmdPtr + STEP_VAL;
      btFlag <= 1'b0;
    end else if (ptrLoad) begin
      cmdPtr <= ptrLoadValue & ALIGN_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPending <= 1'b0;
    end else if (strobes.raiseIrq) begin
      irqPending <= 1'b1;
    end else if (irqClear) begin
      irqPending <= 1'b0;
    end
  end
endmodule

// File: rtl/cbwi_ctrl.sv
module cbwi_ctrl
  import cbwi_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evalStrobe,
  input  logic [1:0]           waitMode,
  input  logic [1:0]           intrMode,
  input  logic [1:0]           branchMode,
  input  logic [DEC_COUNT-1:0] condHit,
  output cbwi_strobe_t         strobes,
  output logic                 decValid,
  output logic                 waitFlag,
  output logic                 irqPulse,
  output logic                 branchTaken
);
  cbwi_mode_e waitCap, intrCap, branchCap;
  logic       validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ    <= 1'b0;
      waitCap   <= MODE_NEVER;
      intrCap   <= MODE_NEVER;
      branchCap <= MODE_NEVER;
    end else begin
      validQ <= evalStrobe;
      if (evalStrobe) begin
        waitCap   <= cbwi_mode_e'(waitMode);
        intrCap   <= cbwi_mode_e'(intrMode);
        branchCap <= cbwi_mode_e'(branchMode);
      end
    end
  end

  logic waitHit, proceed, irqHit, brHit;

  always_comb begin
    waitHit = validQ && modeFires(waitCap, condHit[DEC_WAIT]);
    proceed = validQ && !waitHit;
    irqHit  = proceed && modeFires(intrCap, condHit[DEC_INTR]);
    brHit   = proceed && modeFires(branchCap, condHit[DEC_BRANCH]);

    strobes.commitBranch  = brHit;
    strobes.commitAdvance = proceed && !brHit;
    strobes.raiseIrq      = irqHit;

    decValid    = validQ;
    waitFlag    = waitHit;
    irqPulse    = irqHit;
    branchTaken = brHit;
  end
endmodule

// File: rtl/cbwi_unit.sv
module cbwi_unit
  import cbwi_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int STAT_W     = 4,
  parameter int STEP_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalStrobe,
  input  logic [1:0]        waitMode,
  input  logic [1:0]        intrMode,
  input  logic [1:0]        branchMode,
  input  logic [STAT_W-1:0] devStatus,
  input  logic [STAT_W-1:0] waitMask,
  input  logic [STAT_W-1:0] waitValue,
  input  logic [STAT_W-1:0] intrMask,
  input  logic [STAT_W-1:0] intrValue,
  input  logic [STAT_W-1:0] branchMask,
  input  logic [STAT_W-1:0] branchValue,
  input  logic [ADDR_W-1:0] depWord,
  input  logic              ptrLoad,
  input  logic [ADDR_W-1:0] ptrLoadValue,
  input  logic              irqClear,
  output logic              decValid,
  output logic              waitFlag,
  output logic              irqPulse,
  output logic              branchTaken,
  output logic [ADDR_W-1:0] cmdPtr,
  output logic              btFlag,
  output logic              irqPending
);
  logic [DEC_COUNT-1:0][STAT_W-1:0] maskBus;
  logic [DEC_COUNT-1:0][STAT_W-1:0] valueBus;
  logic [DEC_COUNT-1:0]             condHit;
  cbwi_strobe_t                     strobes;

  always_comb begin
    maskBus[DEC_WAIT]    = waitMask;
    maskBus[DEC_INTR]    = intrMask;
    maskBus[DEC_BRANCH]  = branchMask;
    valueBus[DEC_WAIT]   = waitValue;
    valueBus[DEC_INTR]   = intrValue;
    valueBus[DEC_BRANCH] = branchValue;
  end

  cbwi_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .evalStrobe  (evalStrobe),
    .waitMode    (waitMode),
    .intrMode    (intrMode),
    .branchMode  (branchMode),
    .condHit     (condHit),
    .strobes     (strobes),
    .decValid    (decValid),
    .waitFlag    (waitFlag),
    .irqPulse    (irqPulse),
    .branchTaken (branchTaken)
  );

  cbwi_datapath #(
    .ADDR_W     (ADDR_W),
    .STAT_W     (STAT_W),
    .STEP_BYTES (STEP_BYTES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .capture      (evalStrobe),
    .devStatus    (devStatus),
    .maskIn       (maskBus),
    .valueIn      (valueBus),
    .depWord      (depWord),
    .ptrLoad      (ptrLoad),
    .ptrLoadValue (ptrLoadValue),
    .irqClear     (irqClear),
    .strobes      (strobes),
    .condHit      (condHit),
    .cmdPtr       (cmdPtr),
    .btFlag       (btFlag),
    .irqPending   (irqPending)
  );
endmodule

// File: rtl/cbwi_unit_chk.sv
module cbwi_unit_chk #(
  parameter int ADDR_W     = 32,
  parameter int STEP_BYTES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              evalStrobe,
  input logic [ADDR_W-1:0] depWord,
  input logic              ptrLoad,
  input logic              decValid,
  input logic              waitFlag,
  input logic              irqPulse,
  input logic              branchTaken,
  input logic [ADDR_W-1:0] cmdPtr,
  input logic              btFlag,
  input logic              irqPending
);
  localparam logic [ADDR_W-1:0] STEP_VAL = ADDR_W'(STEP_BYTES);

  p_valid_follows_eval_r4: assert property (@(posedge clk) disable iff (!rstN)
    evalStrobe |=> decValid);

  p_valid_only_after_eval_r4: assert property (@(posedge clk) disable iff (!rstN)
    !evalStrobe |=> !decValid);

  p_quiet_when_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> (!waitFlag && !irqPulse && !branchTaken));

  p_wait_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && waitFlag) |-> (!irqPulse && !branchTaken));

  p_wait_holds_ptr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && waitFlag && !ptrLoad) |=> ($stable(cmdPtr) && $stable(btFlag)));

  p_branch_loads_r6: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && branchTaken) |=> (btFlag && cmdPtr == $past(depWord, 2)));

  p_fall_advances_r7: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !waitFlag && !branchTaken) |=>
      (!btFlag && cmdPtr == $past(cmdPtr) + STEP_VAL));

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> irqPending);
endmodule

bind cbwi_unit cbwi_unit_chk #(.ADDR_W(ADDR_W), .STEP_BYTES(STEP_BYTES)) u_chk (.*);

// File: tb/cbwi_unit_tb.sv
module cbwi_unit_tb;
  localparam int AW = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          evalStrobe = 1'b0;
  logic [1:0]    waitMode = '0, intrMode = '0, branchMode = '0;
  logic [SW-1:0] devStatus = '0;
  logic [SW-1:0] waitMask = '0, waitValue = '0;
  logic [SW-1:0] intrMask = '0, intrValue = '0;
  logic [SW-1:0] branchMask = '0, branchValue = '0;
  logic [AW-1:0] depWord = '0;
  logic          ptrLoad = 1'b0;
  logic [AW-1:0] ptrLoadValue = '0;
  logic          irqClear = 1'b0;
  logic          decValid, waitFlag, irqPulse, branchTaken, btFlag, irqPending;
  logic [AW-1:0] cmdPtr;

  int checks = 0;
  int failures = 0;
  logic [AW-1:0] expPtr = '0;
  logic          expBt = 1'b0;
  logic          expPend = 1'b0;

  always #2 clk = ~clk;

  cbwi_unit #(.ADDR_W(AW), .STAT_W(SW), .STEP_BYTES(16)) u_dut (
    .clk(clk), .rstN(rstN), .evalStrobe(evalStrobe),
    .waitMode(waitMode), .intrMode(intrMode), .branchMode(branchMode),
    .devStatus(devStatus),
    .waitMask(waitMask), .waitValue(waitValue),
    .intrMask(intrMask), .intrValue(intrValue),
    .branchMask(branchMask), .branchValue(branchValue),
    .depWord(depWord), .ptrLoad(ptrLoad), .ptrLoadValue(ptrLoadValue),
    .irqClear(irqClear),
    .decValid(decValid), .waitFlag(waitFlag), .irqPulse(irqPulse),
    .branchTaken(branchTaken), .cmdPtr(cmdPtr), .btFlag(btFlag),
    .irqPending(irqPending)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic condOf(logic [3:0] st, logic [3:0] m, logic [3:0] v);
    return ((st & m) == (v & m));
  endfunction

  function automatic logic fires(logic [1:0] mode, logic c);
    case (mode)
      2'd0: return 1'b0;
      2'd1: return c;
      2'd2: return !c;
      default: return 1'b1;
    endcase
  endfunction

  // One descriptor completion; clrSame/loadSame are applied in the decision cycle.
  task automatic decide(input string req,
                        input logic [1:0] wm, input logic [1:0] im, input logic [1:0] bm,
                        input logic [3:0] st,
                        input logic [3:0] wMk, input logic [3:0] wVl,
                        input logic [3:0] iMk, input logic [3:0] iVl,
                        input logic [3:0] bMk, input logic [3:0] bVl,
                        input logic [AW-1:0] dep,
                        input logic clrSame, input logic loadSame,
                        input logic [AW-1:0] ldVal);
    logic eW, eI, eB;
    eW = fires(wm, condOf(st, wMk, wVl));
    eI = !eW && fires(im, condOf(st, iMk, iVl));
    eB = !eW && fires(bm, condOf(st, bMk, bVl));
    @(negedge clk);
    evalStrobe = 1'b1; waitMode = wm; intrMode = im; branchMode = bm;
    devStatus = st; waitMask = wMk; waitValue = wVl; intrMask = iMk; intrValue = iVl;
    branchMask = bMk; branchValue = bVl; depWord = dep;
    @(negedge clk);
    evalStrobe = 1'b0; devStatus = ~st; depWord = ~dep;
    irqClear = clrSame; ptrLoad = loadSame; ptrLoadValue = ldVal;
    chk("R4", "decValid", 32'(decValid), 32'd1);
    chk(req, "waitFlag", 32'(waitFlag), 32'(eW));
    chk(req, "irqPulse", 32'(irqPulse), 32'(eI));
    chk(req, "branchTaken", 32'(branchTaken), 32'(eB));
    if (!eW) begin
      if (eB) begin expPtr = dep; expBt = 1'b1; end
      else begin expPtr = expPtr + 16'd16; expBt = 1'b0; end
    end else if (loadSame) begin
      expPtr = ldVal & 16'hFFF0;
    end
    if (eI) expPend = 1'b1;
    else if (clrSame) expPend = 1'b0;
    @(negedge clk);
    irqClear = 1'b0; ptrLoad = 1'b0;
    chk("R4", "decValid idle", 32'(decValid), 32'd0);
    chk(req, "cmdPtr", 32'(cmdPtr), 32'(expPtr));
    chk(req, "btFlag", 32'(btFlag), 32'(expBt));
    chk(req, "irqPending", 32'(irqPending), 32'(expPend));
  endtask

  task automatic loadPtr(input logic [AW-1:0] v);
    @(negedge clk);
    ptrLoad = 1'b1; ptrLoadValue = v;
    @(negedge clk);
    ptrLoad = 1'b0;
    expPtr = v & 16'hFFF0;
    chk("R9", "cmdPtr after load", 32'(cmdPtr), 32'(expPtr));
  endtask

  task automatic clearIrq();
    @(negedge clk);
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;
    expPend = 1'b0;
    chk("R8", "irqPending after clear", 32'(irqPending), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "cmdPtr", 32'(cmdPtr), 32'd0);
    chk("R1", "btFlag", 32'(btFlag), 32'd0);
    chk("R1", "irqPending", 32'(irqPending), 32'd0);
    chk("R1", "decValid", 32'(decValid), 32'd0);
    chk("R4", "quiet outputs", 32'({waitFlag, irqPulse, branchTaken}), 32'd0);
  endtask

  task automatic t_conditions();
    loadPtr(16'h1237);
    // R2: full mask match, partial mask, zero mask, mismatch
    decide("R2", 2'd0, 2'd1, 2'd1, 4'hA, 4'h0, 4'h0, 4'hF, 4'hA, 4'hF, 4'hB, 16'h4000, 1'b0, 1'b0, '0);
    decide("R2", 2'd0, 2'd1, 2'd1, 4'h6, 4'h0, 4'h0, 4'h4, 4'h5, 4'h3, 4'h0, 16'h4100, 1'b0, 1'b0, '0);
    decide("R2", 2'd0, 2'd2, 2'd1, 4'h9, 4'h0, 4'h0, 4'h0, 4'hF, 4'h0, 4'h3, 16'h4200, 1'b0, 1'b0, '0);
    clearIrq();
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++) begin
      decide("R3", 2'd0, 2'(m), 2'(m), 4'h5, 4'h0, 4'h0, 4'hF, 4'h5, 4'hF, 4'h5,
             16'h2000 + 16'(m * 16'h100), 1'b0, 1'b0, '0);
      decide("R3", 2'd0, 2'(m), 2'(m), 4'h5, 4'h0, 4'h0, 4'hF, 4'h4, 4'hF, 4'h4,
             16'h3000 + 16'(m * 16'h100), 1'b1, 1'b0, '0);
    end
  endtask

  task automatic t_wait();
    decide("R5", 2'd3, 2'd3, 2'd3, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16'h7770, 1'b0, 1'b0, '0);
    decide("R5", 2'd1, 2'd3, 2'd3, 4'hC, 4'hC, 4'h4, 4'h0, 4'h0, 4'h0, 4'h0, 16'h7780, 1'b0, 1'b0, '0);
    decide("R5", 2'd2, 2'd3, 2'd3, 4'hC, 4'hC, 4'hC, 4'h0, 4'h0, 4'h0, 4'h0, 16'h7790, 1'b0, 1'b0, '0);
    decide("R5", 2'd1, 2'd3, 2'd0, 4'hC, 4'hC, 4'h8, 4'h0, 4'h0, 4'h0, 4'h0, 16'h77A0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_branch_fall();
    decide("R6", 2'd0, 2'd0, 2'd3, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16'hBEE0, 1'b0, 1'b0, '0);
    decide("R7", 2'd0, 2'd0, 2'd0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16'h1110, 1'b0, 1'b0, '0);
    loadPtr(16'hFFF5);
    decide("R7", 2'd0, 2'd0, 2'd2, 4'h1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 4'h1, 16'h2220, 1'b0, 1'b0, '0);
    chk("R7", "wrap to zero", 32'(cmdPtr), 32'd0);
  endtask

  task automatic t_sticky();
    clearIrq();
    decide("R8", 2'd0, 2'd3, 2'd0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16'h0, 1'b1, 1'b0, '0);
    decide("R8", 2'd0, 2'd0, 2'd0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16'h0, 1'b0, 1'b0, '0);
    clearIrq();
  endtask

  task automatic t_load_vs_commit();
    loadPtr(16'h5000);
    decide("R9", 2'd0, 2'd0, 2'd3, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16'h6660, 1'b0, 1'b1, 16'h9990);
    decide("R9", 2'd3, 2'd0, 2'd0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16'h0, 1'b0, 1'b1, 16'hABCF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_conditions();
    t_modes();
    t_wait();
    t_branch_fall();
    t_sticky();
    t_load_vs_commit();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule